// File: doc/BRIEF.md
# Programmable-Unit Instruction Dispatch with Configuration Tag

This block sits in the execute stage of a 32-bit RISC pipeline. It handles one custom instruction that runs a function on a reconfigurable functional unit. It splits the instruction word into its register fields and a function number, and compares the function number with a tag register that records which function is currently loaded into the unit. When the two match, the instruction completes in one cycle. When they differ, the block raises a reconfiguration trap so that a handler can load the right configuration.

The tag value 0 means that nothing is loaded. The tag returns to 0 on every exception, on every system call and on its own trap. As a result, the unit never has to be saved on a context switch: the next use after a switch simply misses and reloads.

To make reloading cheap, the block owns the configuration bit store. A single start pulse bulk-clears every bit over a fixed number of cycles while a busy flag stalls issue. The handler then sets only the bits that must be 1. Finally it writes the new function number into the tag through a privileged write, and the faulting instruction is re-issued and hits.

Top module: `pu_dispatch`

## Requirements
- R1: The instruction word is decoded as opcode [31:26], first source register [25:21], second source register [20:16], destination register [15:11] and function number [10:0]. Only opcode 6'h1C (the `CUSTOM_OPC` default) is a custom instruction.
- R2: An accepted custom instruction whose function number equals the tag and is nonzero raises `done_valid` for one cycle on the next clock, with the three register fields and the function number, and does not raise `trap`.
- R3: An accepted custom instruction whose function number differs from the tag raises `trap` on the next clock with `trap_fn` equal to its function number, does not raise `done_valid`, and leaves the tag at 0.
- R4: A custom instruction with function number 0 always traps, including straight after reset while the tag is 0.
- R5: After reset the tag is 0, and `done_valid`, `trap` and `stall` are all 0.
- R6: A pulse on `exc_event` or on `syscall_event` sets the tag to 0 on the next clock, even when a tag write is requested in the same cycle.
- R7: A tag write with no clearing event in the same cycle loads `tag_wr_fn` into the tag on the next clock, and the new value is visible on `cur_tag`.
- R8: An instruction whose opcode is not the custom opcode raises neither `done_valid` nor `trap` and leaves the tag unchanged.
- R9: A `clr_start` pulse while idle holds `stall` high for exactly `CFG_DEPTH` cycles. Afterwards every configuration bit reads 0.
- R10: While `stall` is high, issued instructions produce neither `done_valid` nor `trap`, the tag is unchanged, and `cfg_set_en` and `clr_start` have no effect.
- R11: `cfg_set_en` while idle sets the bit at `cfg_set_addr` to 1 and leaves every other bit unchanged. `cfg_rd_bit` returns the bit at `cfg_rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word present this cycle |
| issue_instr | input | 32 | Instruction word |
| exc_event | input | 1 | Any exception taken by the pipeline |
| syscall_event | input | 1 | System call taken |
| tag_wr_en | input | 1 | Privileged tag write strobe |
| tag_wr_fn | input | 11 | Function number to load into the tag |
| clr_start | input | 1 | Start bulk clear of configuration bits |
| cfg_set_en | input | 1 | Set one configuration bit to 1 |
| cfg_set_addr | input | CFG_AW | Bit address to set |
| cfg_rd_addr | input | CFG_AW | Bit address to read |
| cfg_rd_bit | output | 1 | Registered read data |
| stall | output | 1 | Bulk clear in progress; issue and writes held off |
| cur_tag | output | 11 | Function currently loaded |
| done_valid | output | 1 | Custom instruction completed |
| done_rs | output | 5 | First source register of completed instruction |
| done_rt | output | 5 | Second source register of completed instruction |
| done_rd | output | 5 | Destination register of completed instruction |
| done_fn | output | 11 | Function number of completed instruction |
| trap | output | 1 | Reconfiguration trap |
| trap_fn | output | 11 | Function number that missed |

## Verification
The bench issues function 0 right after reset, when the tag is also 0. A design that compares numbers only would treat this as a hit and run an unconfigured unit. It fires exceptions and system calls in the same cycle as a tag write, which catches a design that gives the write priority, and it re-issues a missed function to confirm that the trap cleared the tag. During a bulk clear it issues a hitting instruction, retriggers the clear and sets bit 0, which the sequencer has already passed. A design that does not gate these would complete the instruction, lengthen the busy window or leave bit 0 set. A full readback after a sparse reload then exposes any bit that was written or lost outside the chosen address set.

// File: rtl/pu_dispatch_pkg.sv
package pu_dispatch_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_W   = 5;
  localparam int FN_W    = 11;
  // Field boundaries, counted from the least significant bit
  localparam int FN_LSB  = 0;
  localparam int RD_LSB  = FN_LSB + FN_W;
  localparam int RT_LSB  = RD_LSB + REG_W;
  localparam int RS_LSB  = RT_LSB + REG_W;
  localparam int OPC_LSB = RS_LSB + REG_W;
  localparam logic [FN_W-1:0] FN_EMPTY = '0;

  typedef struct packed {
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rd;
    logic [FN_W-1:0]  fn;
  } xop_fields_t;
endpackage

// File: rtl/xop_decode.sv
module xop_decode
  import pu_dispatch_pkg::*;
#(
  parameter logic [OPC_W-1:0] CUSTOM_OPC = 6'h1C
) (
  input  logic [INSTR_W-1:0] instr,
  output xop_fields_t        fields,
  output logic               is_custom
);
  always_comb begin
    fields.rs = instr[RS_LSB +: REG_W];
    fields.rt = instr[RT_LSB +: REG_W];
    fields.rd = instr[RD_LSB +: REG_W];
    fields.fn = instr[FN_LSB +: FN_W];
    is_custom = (instr[OPC_LSB +: OPC_W] == CUSTOM_OPC);
  end
endmodule

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import pu_dispatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  xop_fields_t      fields,
  input  logic             exc_event,
  input  logic             syscall_event,
  input  logic             tag_wr_en,
  input  logic [FN_W-1:0]  tag_wr_fn,
  output logic [FN_W-1:0]  tag,
  output logic             done_valid,
  output xop_fields_t      done_fields,
  output logic             trap,
  output logic [FN_W-1:0]  trap_fn
);
  logic hit;
  logic wipe;

  always_comb begin
    hit  = (fields.fn == tag) && (fields.fn != FN_EMPTY);
    wipe = exc_event || syscall_event || (go && !hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag         <= FN_EMPTY;
      done_valid  <= 1'b0;
      done_fields <= '0;
      trap        <= 1'b0;
      trap_fn     <= FN_EMPTY;
    end else begin
      done_valid <= go && hit;
      trap       <= go && !hit;
      if (go && hit)  done_fields <= fields;
      if (go && !hit) trap_fn     <= fields.fn;
      if (wipe)           tag <= FN_EMPTY;
      else if (tag_wr_en) tag <= tag_wr_fn;
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && trap));
  assert_miss_leaves_empty_R3: assert property (@(posedge clk) disable iff (rst)
    trap |-> tag == FN_EMPTY);
  assert_zero_fn_traps_R4: assert property (@(posedge clk) disable iff (rst)
    (go && fields.fn == FN_EMPTY) |=> trap);
  assert_event_clears_tag_R6: assert property (@(posedge clk) disable iff (rst)
    (exc_event || syscall_event) |=> tag == FN_EMPTY);
  assert_tag_load_R7: assert property (@(posedge clk) disable iff (rst)
    (tag_wr_en && !exc_event && !syscall_event && !go) |=> tag == $past(tag_wr_fn));
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_start,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          bits [DEPTH];
  logic [AW-1:0] sweep;
  logic          we;
  logic [AW-1:0] wa;
  logic          wd;

  // One write port shared by the sweep and single-bit sets
  always_comb begin
    we = busy || set_en;
    wa = busy ? sweep : set_addr;
    wd = !busy;
  end

  always_ff @(posedge clk) begin
    if (we) bits[wa] <= wd;
    rd_bit <= bits[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sweep <= '0;
    end else if (!busy) begin
      if (clr_start) begin
        busy  <= 1'b1;
        sweep <= '0;
      end
    end else if (sweep == LAST) begin
      busy <= 1'b0;
    end else begin
      sweep <= sweep + 1'b1;
    end
  end

  assert_sweep_starts_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_start && !busy) |=> (busy && sweep == '0));
  assert_sweep_steps_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && sweep != LAST) |=> (busy && sweep == $past(sweep) + 1'b1));
  assert_sweep_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && sweep == LAST) |=> !busy);
endmodule

// File: rtl/pu_dispatch.sv
module pu_dispatch
  import pu_dispatch_pkg::*;
#(
  parameter logic [5:0] CUSTOM_OPC = 6'h1C,
  parameter int CFG_DEPTH = 512,
  parameter int CFG_AW    = $clog2(CFG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       issue_instr,
  input  logic              exc_event,
  input  logic              syscall_event,
  input  logic              tag_wr_en,
  input  logic [10:0]       tag_wr_fn,
  input  logic              clr_start,
  input  logic              cfg_set_en,
  input  logic [CFG_AW-1:0] cfg_set_addr,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic              cfg_rd_bit,
  output logic              stall,
  output logic [10:0]       cur_tag,
  output logic              done_valid,
  output logic [4:0]        done_rs,
  output logic [4:0]        done_rt,
  output logic [4:0]        done_rd,
  output logic [10:0]       done_fn,
  output logic              trap,
  output logic [10:0]       trap_fn
);
  xop_fields_t fields;
  xop_fields_t done_fields;
  logic        is_custom;
  logic        busy;
  logic        go;

  xop_decode #(.CUSTOM_OPC(CUSTOM_OPC)) u_decode (
    .instr     (issue_instr),
    .fields    (fields),
    .is_custom (is_custom)
  );

  assign go = issue_valid && is_custom && !busy;

  tag_ctrl u_tag (
    .clk           (clk),
    .rst           (rst),
    .go            (go),
    .fields        (fields),
    .exc_event     (exc_event),
    .syscall_event (syscall_event),
    .tag_wr_en     (tag_wr_en),
    .tag_wr_fn     (tag_wr_fn),
    .tag           (cur_tag),
    .done_valid    (done_valid),
    .done_fields   (done_fields),
    .trap          (trap),
    .trap_fn       (trap_fn)
  );

  cfg_store #(.DEPTH(CFG_DEPTH), .AW(CFG_AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .clr_start (clr_start),
    .set_en    (cfg_set_en && !busy),
    .set_addr  (cfg_set_addr),
    .rd_addr   (cfg_rd_addr),
    .rd_bit    (cfg_rd_bit),
    .busy      (busy)
  );

  assign stall   = busy;
  assign done_rs = done_fields.rs;
  assign done_rt = done_fields.rt;
  assign done_rd = done_fields.rd;
  assign done_fn = done_fields.fn;

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!done_valid && !trap));
  assert_foreign_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !is_custom) |=> (!done_valid && !trap));
endmodule

// File: tb/pu_dispatch_test.sv
module pu_dispatch_test;
  localparam int DEPTH = 512;
  localparam int AW = $clog2(DEPTH);
  localparam logic [5:0] OPC = 6'h1C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 0;
  logic [31:0] issue_instr = '0;
  logic exc_event = 0, syscall_event = 0, tag_wr_en = 0;
  logic [10:0] tag_wr_fn = '0;
  logic clr_start = 0, cfg_set_en = 0;
  logic [AW-1:0] cfg_set_addr = '0, cfg_rd_addr = '0;
  logic cfg_rd_bit, stall, done_valid, trap;
  logic [10:0] cur_tag, done_fn, trap_fn;
  logic [4:0] done_rs, done_rt, done_rd;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pu_dispatch #(.CUSTOM_OPC(OPC), .CFG_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .exc_event(exc_event), .syscall_event(syscall_event),
    .tag_wr_en(tag_wr_en), .tag_wr_fn(tag_wr_fn), .clr_start(clr_start),
    .cfg_set_en(cfg_set_en), .cfg_set_addr(cfg_set_addr),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_bit(cfg_rd_bit), .stall(stall),
    .cur_tag(cur_tag), .done_valid(done_valid), .done_rs(done_rs),
    .done_rt(done_rt), .done_rd(done_rd), .done_fn(done_fn),
    .trap(trap), .trap_fn(trap_fn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input logic [4:0] rd, input logic [10:0] fn);
    return {op, rs, rt, rd, fn};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk); issue_valid = 1; issue_instr = w;
    @(negedge clk); issue_valid = 0;
  endtask

  task automatic write_tag(input logic [10:0] v);
    @(negedge clk); tag_wr_en = 1; tag_wr_fn = v;
    @(negedge clk); tag_wr_en = 0;
  endtask

  task automatic set_bit(input int a);
    @(negedge clk); cfg_set_en = 1; cfg_set_addr = AW'(a);
    @(negedge clk); cfg_set_en = 0;
  endtask

  task automatic t_reset;
    chk("R5 tag", cur_tag, 0);
    chk("R5 done", done_valid, 0);
    chk("R5 trap", trap, 0);
    chk("R5 stall", stall, 0);
  endtask

  task automatic t_zero_fn;
    issue(mk(OPC, 1, 2, 3, 0));
    chk("R4 trap on fn0 after reset", trap, 1);
    chk("R4 no done", done_valid, 0);
    chk("R4 trap_fn", trap_fn, 0);
  endtask

  task automatic t_hit;
    write_tag(11'h123);
    chk("R7 tag loaded", cur_tag, 11'h123);
    issue(mk(OPC, 5'd3, 5'd17, 5'd30, 11'h123));
    chk("R2 done", done_valid, 1);
    chk("R2 no trap", trap, 0);
    chk("R1 rs", done_rs, 3);
    chk("R1 rt", done_rt, 17);
    chk("R1 rd", done_rd, 30);
    chk("R1 fn", done_fn, 11'h123);
    @(negedge clk);
    chk("R2 single pulse", done_valid, 0);
    issue(mk(OPC, 5'd31, 5'd0, 5'd1, 11'h123));
    chk("R2 second hit", done_valid, 1);
    chk("R1 rs pattern2", done_rs, 31);
    chk("R1 rt pattern2", done_rt, 0);
    chk("R1 rd pattern2", done_rd, 1);
    chk("R7 tag kept on hit", cur_tag, 11'h123);
  endtask

  task automatic t_foreign;
    issue(mk(6'h1D, 5'd3, 5'd4, 5'd5, 11'h123));
    chk("R8 no done", done_valid, 0);
    chk("R8 no trap", trap, 0);
    chk("R8 tag kept", cur_tag, 11'h123);
  endtask

  task automatic t_miss;
    issue(mk(OPC, 5'd7, 5'd8, 5'd9, 11'h124));
    chk("R3 trap", trap, 1);
    chk("R3 no done", done_valid, 0);
    chk("R3 trap_fn", trap_fn, 11'h124);
    chk("R3 tag cleared", cur_tag, 0);
    issue(mk(OPC, 5'd7, 5'd8, 5'd9, 11'h123));
    chk("R3 old fn now misses", trap, 1);
    write_tag(11'h124);
    issue(mk(OPC, 5'd7, 5'd8, 5'd9, 11'h124));
    chk("R2 reissue hits", done_valid, 1);
    write_tag(11'h7FF);
    issue(mk(OPC, 5'd1, 5'd1, 5'd1, 0));
    chk("R4 fn0 misses with tag set", trap, 1);
  endtask

  task automatic t_events;
    write_tag(11'h055);
    @(negedge clk); exc_event = 1;
    @(negedge clk); exc_event = 0;
    chk("R6 exception clears", cur_tag, 0);
    write_tag(11'h056);
    @(negedge clk); syscall_event = 1;
    @(negedge clk); syscall_event = 0;
    chk("R6 syscall clears", cur_tag, 0);
    @(negedge clk); exc_event = 1; tag_wr_en = 1; tag_wr_fn = 11'h321;
    @(negedge clk); exc_event = 0; tag_wr_en = 0;
    chk("R6 clear beats write", cur_tag, 0);
  endtask

  task automatic t_reload;
    int n;
    set_bit(9);
    set_bit(400);
    write_tag(11'h2A5);
    @(negedge clk); clr_start = 1;
    @(negedge clk); clr_start = 0;
    n = 0;
    while (stall && n < DEPTH + 20) begin
      n++;
      if (n == 4) begin
        chk("R10 no done while busy", done_valid, 0);
        chk("R10 no trap while busy", trap, 0);
      end
      if (n == 3) begin
        issue_valid = 1; issue_instr = mk(OPC, 2, 2, 2, 11'h2A5);
        cfg_set_en = 1; cfg_set_addr = '0; clr_start = 1;
      end else begin
        issue_valid = 0; cfg_set_en = 0; clr_start = 0;
      end
      @(negedge clk);
    end
    issue_valid = 0; cfg_set_en = 0; clr_start = 0;
    chk("R9 busy length", n, DEPTH);
    chk("R10 tag unchanged", cur_tag, 11'h2A5);
    set_bit(3); set_bit(64); set_bit(200); set_bit(DEPTH - 1);
    for (int a = 0; a < DEPTH; a++) begin
      logic e;
      e = (a == 3 || a == 64 || a == 200 || a == DEPTH - 1);
      @(negedge clk); cfg_rd_addr = AW'(a);
      @(negedge clk);
      chk($sformatf("R11/R9/R10 bit %0d", a), cfg_rd_bit, e);
    end
    issue(mk(OPC, 2, 2, 2, 11'h2A5));
    chk("R2 hit after reload", done_valid, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_zero_fn();
    t_hit();
    t_foreign();
    t_miss();
    t_events();
    t_reload();
    finish_run();
  end
endmodule